// File: doc/BRIEF.md
# SPI Serial Memory Slave

This block is a byte-addressed memory behind a mode-0 SPI slave port. A host lowers chip select, shifts in an 8-bit command and a 24-bit address, and then moves data bytes in or out for as long as chip select stays low. Three commands are decoded: plain read, write, and fast read. Fast read places one dummy byte between the address and the data. The address steps by one after every data byte and wraps from the top of the array back to zero, so a burst can run without limit.

The SPI pins are oversampled by the block's system clock through a short synchronizer, so all state lives in one clock domain. The array depth is a parameter. Only the low `ADDR_W` bits of the 24-bit address select a byte; the remaining upper bits are don't-care. The serial output comes with an enable, and a pad drives high impedance whenever that enable is low. Raising chip select ends the command at any bit, and the next frame always starts with a new command byte.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset, and whenever chip select is high, `miso_oe_o` is low, which means the output is high impedance.
- R2: `mosi_i` is sampled on rising `sck_i`, MSB first. The first 8 bits form the command: 0x03 is read, 0x02 is write and 0x0B is fast read. A 24-bit address follows, MSB first. `miso_oe_o` stays low through the command and the address.
- R3: Only address bits [ADDR_W-1:0] select the byte. Address bits 23 down to ADDR_W have no effect on reads or writes.
- R4: On read, the first data bit is driven on the falling edge after the last address bit. Data is sent MSB first and changes only on falling edges. `miso_oe_o` is high only during the data phase.
- R5: Fast read takes 8 dummy clocks after the address, with `miso_oe_o` low. The data then starts on the falling edge after the last dummy bit.
- R6: A write stores a byte only once all 8 of its bits have been sampled. A byte cut short by chip select rising leaves the array unchanged.
- R7: While chip select stays low, each complete data byte advances the address by one, for both reads and writes.
- R8: Stepping past address 2^ADDR_W-1 wraps to address 0, and the burst continues.
- R9: `mosi_i` has no effect during the read data phase.
- R10: Any other command value makes the block ignore the rest of the frame: nothing is written and `miso_oe_o` stays low.
- R11: Raising chip select in the middle of a command ends it and drops `miso_oe_o`. The next frame is decoded from its command byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used for oversampling |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock, idles low |
| mosi_i | input | 1 | Serial data into the block |
| miso_o | output | 1 | Serial data out of the block |
| miso_oe_o | output | 1 | Output enable for `miso_o`; low means high impedance |

## Verification
Each SPI edge passes through the two-stage synchronizer and an edge-detect flop. A sampled input bit therefore takes effect three system clocks after the rising `sck_i`, and a write reaches the array on that same cycle. A read bit appears on `miso_o` three to four system clocks after the falling `sck_i`. The bench holds each half period of `sck_i` for eight system clocks and samples `miso_o` and `miso_oe_o` just before each rising `sck_i`, as a host does, so every result is settled well before it is read. After chip select rises, the bench waits four half periods before it checks the idle output or starts the next frame.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam int ADDR_BITS = 24;
  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_WRITE = 8'h02;
  localparam logic [7:0] OPC_FREAD = 8'h0B;

  typedef enum logic [2:0] {ST_OPC, ST_ADDR, ST_DUMMY, ST_RD, ST_WR, ST_SKIP} st_e;
  typedef enum logic [1:0] {CMD_RD, CMD_WR, CMD_FRD} cmd_e;
endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic mosi_i,
  output logic cs_act_o,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic mosi_o
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] cs_ff, sck_ff, mosi_ff;
  logic         sck_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_ff   <= '1;
      sck_ff  <= '0;
      mosi_ff <= '0;
      sck_d   <= 1'b0;
    end else begin
      cs_ff   <= {cs_ff[TOP-1:0], cs_ni};
      sck_ff  <= {sck_ff[TOP-1:0], sck_i};
      mosi_ff <= {mosi_ff[TOP-1:0], mosi_i};
      sck_d   <= sck_ff[TOP];
    end
  end

  assign cs_act_o   = ~cs_ff[TOP];
  assign sck_rise_o = sck_ff[TOP] & ~sck_d;
  assign sck_fall_o = ~sck_ff[TOP] & sck_d;
  assign mosi_o     = mosi_ff[TOP];
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              mosi_i,
  input  logic [7:0]        rdata_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        wdata_o,
  output logic              miso_o,
  output logic              miso_oe_o,
  output st_e               state_o
);
  localparam int CNT_W = $clog2(ADDR_BITS);
  localparam int SH_W  = (ADDR_W - 1 > 7) ? ADDR_W - 1 : 7;
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(7);
  localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_BITS - 1);

  st_e               state_q;
  cmd_e              cmd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SH_W-1:0]   sh_q;
  logic [ADDR_W-1:0] addr_q;
  logic [6:0]        obuf_q;
  logic              miso_q, oe_q;
  logic [7:0]        byte_in;

  assign byte_in = {sh_q[6:0], mosi_i};
  // commit strictly on the 8th sampled bit
  assign we_o    = cs_act_i && sck_rise_i && (state_q == ST_WR) && (cnt_q == LAST_BIT);
  assign wdata_o = byte_in;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OPC;
      cmd_q   <= CMD_RD;
      cnt_q   <= '0;
      sh_q    <= '0;
      addr_q  <= '0;
      obuf_q  <= '0;
      miso_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else if (!cs_act_i) begin
      state_q <= ST_OPC;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else begin
      if (sck_rise_i) begin
        unique case (state_q)
          ST_OPC: begin
            sh_q  <= {sh_q[SH_W-2:0], mosi_i};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              cnt_q <= '0;
              unique case (byte_in)
                OPC_READ:  begin cmd_q <= CMD_RD;  state_q <= ST_ADDR; end
                OPC_WRITE: begin cmd_q <= CMD_WR;  state_q <= ST_ADDR; end
                OPC_FREAD: begin cmd_q <= CMD_FRD; state_q <= ST_ADDR; end
                default:   state_q <= ST_SKIP;
              endcase
            end
          end
          ST_ADDR: begin
            sh_q  <= {sh_q[SH_W-2:0], mosi_i};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST_ADDR) begin
              cnt_q  <= '0;
              addr_q <= {sh_q[ADDR_W-2:0], mosi_i};
              unique case (cmd_q)
                CMD_WR:  state_q <= ST_WR;
                CMD_FRD: state_q <= ST_DUMMY;
                default: state_q <= ST_RD;
              endcase
            end
          end
          ST_DUMMY: begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              cnt_q   <= '0;
              state_q <= ST_RD;
            end
          end
          ST_WR: begin
            sh_q  <= {sh_q[SH_W-2:0], mosi_i};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              cnt_q  <= '0;
              addr_q <= addr_q + 1'b1;
            end
          end
          ST_RD: begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              cnt_q  <= '0;
              addr_q <= addr_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (sck_fall_i && state_q == ST_RD) begin
        oe_q <= 1'b1;
        if (cnt_q == '0) begin
          miso_q <= rdata_i[7];
          obuf_q <= rdata_i[6:0];
        end else begin
          miso_q <= obuf_q[6];
          obuf_q <= {obuf_q[5:0], 1'b0};
        end
      end
    end
  end

  assign addr_o    = addr_q;
  assign miso_o    = miso_q;
  assign miso_oe_o = oe_q;
  assign state_o   = state_q;
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic mosi_i,
  output logic miso_o,
  output logic miso_oe_o
);
  logic              cs_act, sck_rise, sck_fall, mosi_s;
  logic              mem_we;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        wdata, rdata;
  spi_mem_pkg::st_e  state;

  spi_mem_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .sck_i      (sck_i),
    .mosi_i     (mosi_i),
    .cs_act_o   (cs_act),
    .sck_rise_o (sck_rise),
    .sck_fall_o (sck_fall),
    .mosi_o     (mosi_s)
  );

  spi_mem_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_act_i   (cs_act),
    .sck_rise_i (sck_rise),
    .sck_fall_i (sck_fall),
    .mosi_i     (mosi_s),
    .rdata_i    (rdata),
    .we_o       (mem_we),
    .addr_o     (addr),
    .wdata_o    (wdata),
    .miso_o     (miso_o),
    .miso_oe_o  (miso_oe_o),
    .state_o    (state)
  );

  spi_mem_array #(.ADDR_W(ADDR_W)) u_array (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .waddr_i (addr),
    .wdata_i (wdata),
    .raddr_i (addr),
    .rdata_o (rdata)
  );
endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_act_i,
  input logic              sck_rise_i,
  input logic              sck_fall_i,
  input logic              we_i,
  input st_e               state_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              miso_i,
  input logic              miso_oe_i
);
  logic in_data;
  assign in_data = (state_i == ST_RD) || (state_i == ST_WR);

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> !miso_oe_i); // R1
  AST_OE_IN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miso_oe_i |-> (state_i == ST_RD)); // R4
  AST_MISO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miso_oe_i && !sck_fall_i) |=> $stable(miso_i)); // R4
  AST_DUMMY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_DUMMY) |-> !miso_oe_i); // R5
  AST_WE_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (sck_rise_i && cs_act_i)); // R6
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_data && $past(in_data) && (addr_i != $past(addr_i)))
      |-> (addr_i == ADDR_W'($past(addr_i) + 1'b1))); // R7
  AST_SKIP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_SKIP) |-> (!miso_oe_i && !we_i)); // R10
endmodule

bind spi_mem_slave spi_mem_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_act_i   (cs_act),
  .sck_rise_i (sck_rise),
  .sck_fall_i (sck_fall),
  .we_i       (mem_we),
  .state_i    (state),
  .addr_i     (addr),
  .miso_i     (miso_o),
  .miso_oe_i  (miso_oe_o)
);

// File: tb/tb_spi_mem_slave.sv
`timescale 1ns/1ps
module tb_spi_mem_slave;
  localparam int AW   = 10;
  localparam int MASK = (1 << AW) - 1;
  localparam int HALF = 32;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso, miso_oe;

  always #2 clk = ~clk;

  spi_mem_slave #(.ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck),
    .mosi_i(mosi), .miso_o(miso), .miso_oe_o(miso_oe)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] ref_mem [1 << AW];
  logic [7:0] exp_q [$];
  string      req_q [$];
  logic [7:0] got_byte;
  event       got_ev;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic bit_io(input logic b, output logic r, output logic oe);
    mosi = b;
    #HALF;
    r  = miso;
    oe = miso_oe;
    sck = 1'b1;
    #HALF;
    sck = 1'b0;
  endtask

  task automatic byte_io(input logic [7:0] tx, output logic [7:0] rx, output int oe_cnt);
    logic r, o;
    oe_cnt = 0;
    for (int i = 7; i >= 0; i--) begin
      bit_io(tx[i], r, o);
      rx[i] = r;
      oe_cnt += int'(o);
    end
  endtask

  task automatic frame_start();
    cs_n = 1'b0;
    #HALF;
  endtask

  task automatic frame_end();
    #HALF;
    cs_n = 1'b1;
    #(4 * HALF);
  endtask

  task automatic header(input logic [7:0] op, input logic [23:0] a, input string req);
    logic [7:0] rx;
    int oc;
    logic [31:0] w;
    w = {op, a};
    for (int i = 3; i >= 0; i--) begin
      byte_io(w[8*i +: 8], rx, oc);
      chk(oc == 0, req, "oe during command/address", oc, 0);
    end
  endtask

  task automatic wr_burst(input logic [23:0] a, input logic [7:0] d [$], input string req);
    logic [7:0] rx;
    int oc;
    frame_start();
    header(8'h02, a, req);
    foreach (d[i]) begin
      byte_io(d[i], rx, oc);
      ref_mem[(int'(a) + i) & MASK] = d[i];
    end
    frame_end();
    chk(miso_oe == 1'b0, "R1", "oe after write frame", int'(miso_oe), 0);
  endtask

  task automatic rd_burst(input bit fast, input logic [23:0] a, input int n,
                          input logic [7:0] fill, input string req);
    logic [7:0] rx;
    int oc;
    frame_start();
    header(fast ? 8'h0B : 8'h03, a, req);
    if (fast) begin
      byte_io(8'hA5, rx, oc);
      chk(oc == 0, "R5", "oe during dummy byte", oc, 0);
    end
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(ref_mem[(int'(a) + i) & MASK]);
      req_q.push_back(req);
      byte_io(fill, rx, oc);
      chk(oc == 8, "R4", "oe samples in data byte", oc, 8);
      got_byte = rx;
      -> got_ev;
    end
    frame_end();
  endtask

  // monitor: compare each received byte against the head of the scoreboard
  initial begin
    forever begin
      @(got_ev);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4", "unexpected read byte", int'(got_byte), 0);
      end else begin
        logic [7:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        chk(got_byte == e, r, "read byte", int'(got_byte), int'(e));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(100000 * 4);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [7:0] rx;
    int oc;
    logic r, o;
    #21;
    chk(miso_oe == 1'b0, "R1", "oe in reset", int'(miso_oe), 0);
    rst_n = 1'b1;
    #(4 * HALF);
    chk(miso_oe == 1'b0, "R1", "oe idle after reset", int'(miso_oe), 0);

    // R2 R6 R7: write burst, read it back
    wr_burst(24'h000010, '{8'h3C, 8'hC3, 8'h5A, 8'h81}, "R6");
    rd_burst(1'b0, 24'h000010, 4, 8'h00, "R2");
    rd_burst(1'b0, 24'h000011, 3, 8'h00, "R7");
    // R5: fast read
    rd_burst(1'b1, 24'h000010, 4, 8'h00, "R5");
    // R8: wrap on write and on read
    wr_burst(24'h0003FE, '{8'hA1, 8'hB2, 8'hC4}, "R8");
    rd_burst(1'b0, 24'h0003FE, 3, 8'h00, "R8");
    rd_burst(1'b1, 24'h0003FF, 2, 8'h00, "R8");
    // R3: upper address bits ignored
    rd_burst(1'b0, 24'hA80010, 2, 8'h00, "R3");
    wr_burst(24'h5C0100, '{8'hE7}, "R3");
    rd_burst(1'b1, 24'h000100, 1, 8'h00, "R3");
    // R6: partial byte dropped
    wr_burst(24'h000020, '{8'h00, 8'h77}, "R6");
    frame_start();
    header(8'h02, 24'h000020, "R6");
    byte_io(8'h11, rx, oc);
    ref_mem[32'h20] = 8'h11;
    bit_io(1'b1, r, o);
    bit_io(1'b0, r, o);
    bit_io(1'b1, r, o);
    bit_io(1'b0, r, o);
    frame_end();
    rd_burst(1'b0, 24'h000020, 2, 8'h00, "R6");
    // R9: input pattern during data has no effect
    rd_burst(1'b0, 24'h000010, 4, 8'hFF, "R9");
    rd_burst(1'b1, 24'h000010, 4, 8'h96, "R9");
    // R10: unknown command ignored for the whole frame
    frame_start();
    byte_io(8'h9F, rx, oc);
    chk(oc == 0, "R10", "oe on unknown command", oc, 0);
    byte_io(8'h02, rx, oc);
    chk(oc == 0, "R10", "oe after unknown command", oc, 0);
    byte_io(8'h00, rx, oc);
    byte_io(8'h00, rx, oc);
    byte_io(8'h10, rx, oc);
    byte_io(8'hEE, rx, oc);
    chk(oc == 0, "R10", "oe late in ignored frame", oc, 0);
    frame_end();
    rd_burst(1'b0, 24'h000010, 1, 8'h00, "R10");
    // R11: abort inside a read, then a new frame decodes normally
    frame_start();
    header(8'h03, 24'h000010, "R11");
    bit_io(1'b0, r, o);
    chk(o == 1'b1, "R4", "oe on first data bit", int'(o), 1);
    chk(r == ref_mem[32'h10][7], "R4", "first data bit is MSB", int'(r), int'(ref_mem[32'h10][7]));
    bit_io(1'b0, r, o);
    cs_n = 1'b1;
    #(4 * HALF);
    chk(miso_oe == 1'b0, "R11", "oe after abort", int'(miso_oe), 0);
    wr_burst(24'h000030, '{8'h5A}, "R11");
    rd_burst(1'b0, 24'h000030, 1, 8'h00, "R11");
    // long burst
    rd_burst(1'b0, 24'h0003FC, 8, 8'h00, "R7");

    chk(exp_q.size() == 0, "R4", "scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule